// File: doc/BRIEF.md
# Burst Loopback Test Unit

This block sits on the clocked side of one switch port and exercises the interconnect links at full speed. In normal operation, bursts that arrive from the switch are handed to the local module unchanged. With loopback enabled, every arriving burst is sent straight back into the switch. On the first word of each burst the unit exchanges the arriving source-port field with a fixed bit field of the data word. The bits taken out of the word become the new destination, and the source value is written into their place. A burst can therefore hop through a chain of ports, each hop consuming the next destination carried in its own payload.

A small launcher drives a test run. A start pulse captures a one-word seed burst and its destination, and sends the seed into the switch. The launcher then counts bursts as they come back. Each returning burst is looped back until the programmed number of returns is reached. The burst that completes the count is absorbed rather than re-sent: its first word and source are held for inspection and a done flag rises. A watchdog ends a run that stalls. If no burst is accepted for a programmed number of cycles, the run ends and a sticky timeout flag is raised.

Every channel uses request/grant flow control. A word moves on a rising clock edge only when both request and grant are high. The datapath is a direct combinational path from ingress to egress, with no storage in between.

Top module: `burst_loop_tester`

## Requirements
- R1: While loopback is off and no run is active, an arriving word is presented on the local port unchanged (loc_req follows in_req, in_gnt follows loc_gnt), and out_req stays low.
- R2: In loopback, the first word of a burst leaves with out_dst equal to bits [FLD_LSB+PW-1:FLD_LSB] of the arriving word (bits [3:0] by default). Those bits of out_data are replaced by in_src, and all other bits pass unchanged.
- R3: Words after the first pass through unchanged, keep the out_dst that was taken from the first word, and carry the tail bit as it arrived.
- R4: A word moves only on an edge where request and grant are both high. In loopback, in_gnt mirrors out_gnt, and a stalled first word is still presented swapped on the following cycle.
- R5: A start pulse while no run is active and no burst is in progress does three things. It clears rounds, done and timeout. It sends one seed word with tail=1 to seed_dst. It holds in_gnt low until the seed is granted.
- R6: While a run is active, rounds increments by one on the first word of each accepted burst. Bursts before the limit are looped back with the swap even if loop_en is low.
- R7: The burst that brings rounds up to iter_limit (a limit of 0 acts as 1) is absorbed with in_gnt high and is not re-sent. Its first word and source go into held_word and held_src. done rises one cycle after its tail is accepted, and busy falls.
- R8: When wd_limit is non-zero, wd_limit consecutive clock edges of an active run with no accepted ingress word do three things: they raise timeout, end the run and withdraw any pending seed. Timeout stays high until the next start.
- R9: An ingress word accepted on the edge where the watchdog would expire takes priority, and timeout stays low.
- R10: A start pulse while a run is active is ignored: no seed is sent and rounds is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loop arriving bursts back into the switch |
| start | input | 1 | Begin a test run |
| seed_dst | input | PW | Destination of the seed burst |
| seed_word | input | DW | Payload of the seed burst |
| iter_limit | input | CW | Number of returns that ends a run |
| wd_limit | input | TW | Idle cycles before timeout, 0 disables |
| in_req | input | 1 | Ingress word valid |
| in_gnt | output | 1 | Ingress word accepted |
| in_data | input | DW | Ingress word |
| in_tail | input | 1 | Ingress last word of burst |
| in_src | input | PW | Ingress source port |
| out_req | output | 1 | Egress word valid |
| out_gnt | input | 1 | Egress word accepted by switch |
| out_data | output | DW | Egress word |
| out_tail | output | 1 | Egress last word of burst |
| out_dst | output | PW | Egress destination port |
| loc_req | output | 1 | Local delivery word valid |
| loc_gnt | input | 1 | Local module accepts word |
| loc_data | output | DW | Local delivery word |
| loc_tail | output | 1 | Local delivery last word |
| loc_src | output | PW | Local delivery source port |
| busy | output | 1 | Run active |
| done | output | 1 | Run completed |
| timeout | output | 1 | Run ended by watchdog |
| rounds | output | CW | Bursts returned in this run |
| held_word | output | DW | First word of the final burst |
| held_src | output | PW | Source of the final burst |

## Verification
Two functions can meet on the same edge: the return of the final burst and the expiry of the watchdog. The bench starts a run with a limit of one and a watchdog limit of five, lets the seed leave at once, and then withholds the return until the fifth idle edge, so that the return is accepted on exactly the edge where the count would run out. The outcome is judged at the ports: done must be high and timeout low, and a separate run with no return must show timeout rising on that same fifth edge and not on the fourth.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL = 2'd0,
    RT_LOOP  = 2'd1,
    RT_SINK  = 2'd2
  } route_e;
endpackage

// File: rtl/lbt_swap.sv
module lbt_swap #(
  parameter int DW      = 36,
  parameter int PW      = 4,
  parameter int FLD_LSB = 0
) (
  input  logic [DW-1:0] word_i,
  input  logic [PW-1:0] src_i,
  output logic [DW-1:0] word_o,
  output logic [PW-1:0] dst_o
);
  localparam int FLD_END = FLD_LSB + PW;

  assign dst_o = word_i[FLD_LSB +: PW];

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b >= FLD_LSB && b < FLD_END) begin : g_fld
      assign word_o[b] = src_i[b-FLD_LSB];
    end else begin : g_keep
      assign word_o[b] = word_i[b];
    end
  end
endmodule

// File: rtl/lbt_framer.sv
module lbt_framer
  import lbt_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic          tail_i,
  input  route_e        route_now_i,
  input  logic [PW-1:0] dst_now_i,
  output logic          first_o,
  output route_e        route_cur_o,
  output logic [PW-1:0] dst_cur_o
);
  logic          first_q, first_d;
  route_e        route_q, route_d;
  logic [PW-1:0] dst_q, dst_d;

  always_comb begin
    first_d = first_q;
    route_d = route_q;
    dst_d   = dst_q;
    if (acc_i) first_d = tail_i;
    if (acc_i && first_q) begin
      route_d = route_now_i;
      dst_d   = dst_now_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      route_q <= RT_LOCAL;
      dst_q   <= '0;
    end else begin
      first_q <= first_d;
      route_q <= route_d;
      dst_q   <= dst_d;
    end
  end

  assign first_o     = first_q;
  assign route_cur_o = first_q ? route_now_i : route_q;
  assign dst_cur_o   = first_q ? dst_now_i : dst_q;
endmodule

// File: rtl/lbt_launcher.sv
module lbt_launcher #(
  parameter int DW = 36,
  parameter int PW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          frame_idle_i,
  input  logic [PW-1:0] seed_dst_i,
  input  logic [DW-1:0] seed_word_i,
  input  logic [CW-1:0] iter_limit_i,
  input  logic          seed_gnt_i,
  input  logic          in_acc_i,
  input  logic          in_first_i,
  input  logic          in_tail_i,
  input  logic          sinking_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [PW-1:0] in_src_i,
  input  logic          expire_i,
  output logic          start_acc_o,
  output logic          seed_pend_o,
  output logic [PW-1:0] seed_dst_o,
  output logic [DW-1:0] seed_word_o,
  output logic          running_o,
  output logic          final_now_o,
  output logic [CW-1:0] rounds_o,
  output logic          done_o,
  output logic [DW-1:0] held_word_o,
  output logic [PW-1:0] held_src_o
);
  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic          run_q, run_d, pend_q, pend_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] sdst_q, sdst_d, hsrc_q, hsrc_d;
  logic [DW-1:0] sword_q, sword_d, hword_q, hword_d;
  logic          start_acc;

  assign start_acc   = start_i && !run_q && frame_idle_i;
  assign final_now_o = run_q && (({1'b0, cnt_q} + ONE) >= {1'b0, iter_limit_i});

  always_comb begin
    run_d   = run_q;
    pend_d  = pend_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    sdst_d  = sdst_q;
    sword_d = sword_q;
    hword_d = hword_q;
    hsrc_d  = hsrc_q;
    if (start_acc) begin
      run_d   = 1'b1;
      pend_d  = 1'b1;
      done_d  = 1'b0;
      cnt_d   = '0;
      sdst_d  = seed_dst_i;
      sword_d = seed_word_i;
    end else begin
      if (pend_q && seed_gnt_i) pend_d = 1'b0;
      if (in_acc_i && in_first_i && run_q) cnt_d = cnt_q + 1'b1;
      if (in_acc_i && in_first_i && sinking_i) begin
        hword_d = in_data_i;
        hsrc_d  = in_src_i;
      end
      if (in_acc_i && in_tail_i && sinking_i) begin
        done_d = 1'b1;
        run_d  = 1'b0;
      end else if (expire_i) begin
        run_d  = 1'b0;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      sdst_q  <= '0;
      sword_q <= '0;
      hword_q <= '0;
      hsrc_q  <= '0;
    end else begin
      run_q   <= run_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      sdst_q  <= sdst_d;
      sword_q <= sword_d;
      hword_q <= hword_d;
      hsrc_q  <= hsrc_d;
    end
  end

  assign start_acc_o = start_acc;
  assign seed_pend_o = pend_q;
  assign seed_dst_o  = sdst_q;
  assign seed_word_o = sword_q;
  assign running_o   = run_q;
  assign rounds_o    = cnt_q;
  assign done_o      = done_q;
  assign held_word_o = hword_q;
  assign held_src_o  = hsrc_q;

  // R6
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R7
  done_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(in_acc_i && in_tail_i && sinking_i));
endmodule

// File: rtl/lbt_watchdog.sv
module lbt_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          acc_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o,
  output logic          timeout_o
);
  localparam logic [TW:0] ONE = (TW+1)'(1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          to_q, to_d, expire;

  assign expire = run_i && !acc_i && !clear_i && (limit_i != '0)
                  && (({1'b0, cnt_q} + ONE) == {1'b0, limit_i});

  always_comb begin
    cnt_d = cnt_q;
    to_d  = to_q;
    if (clear_i) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (acc_i) begin
      cnt_d = '0;
    end else if (run_i && cnt_q != '1) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (expire) to_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign expire_o  = expire;
  assign timeout_o = to_q;

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !clear_i) |=> to_q);

  // R9
  accept_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> !$past(acc_i));
endmodule

// File: rtl/burst_loop_tester.sv
module burst_loop_tester
  import lbt_pkg::*;
#(
  parameter int DW      = 36,
  parameter int PW      = 4,
  parameter int FLD_LSB = 0,
  parameter int CW      = 8,
  parameter int TW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_en,
  input  logic          start,
  input  logic [PW-1:0] seed_dst,
  input  logic [DW-1:0] seed_word,
  input  logic [CW-1:0] iter_limit,
  input  logic [TW-1:0] wd_limit,
  input  logic          in_req,
  output logic          in_gnt,
  input  logic [DW-1:0] in_data,
  input  logic          in_tail,
  input  logic [PW-1:0] in_src,
  output logic          out_req,
  input  logic          out_gnt,
  output logic [DW-1:0] out_data,
  output logic          out_tail,
  output logic [PW-1:0] out_dst,
  output logic          loc_req,
  input  logic          loc_gnt,
  output logic [DW-1:0] loc_data,
  output logic          loc_tail,
  output logic [PW-1:0] loc_src,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [CW-1:0] rounds,
  output logic [DW-1:0] held_word,
  output logic [PW-1:0] held_src
);
  logic [DW-1:0] swap_word, seed_word_q;
  logic [PW-1:0] swap_dst, dst_cur, seed_dst_q;
  logic          first, in_acc, start_acc, seed_pend, running, final_now, expire;
  route_e        route_now, route_cur;

  assign in_acc    = in_req && in_gnt;
  assign route_now = final_now ? RT_SINK : ((loop_en || running) ? RT_LOOP : RT_LOCAL);

  lbt_swap #(.DW(DW), .PW(PW), .FLD_LSB(FLD_LSB)) u_swap (
    .word_i(in_data), .src_i(in_src), .word_o(swap_word), .dst_o(swap_dst)
  );

  lbt_framer #(.PW(PW)) u_framer (
    .clk(clk), .rst_n(rst_n), .acc_i(in_acc), .tail_i(in_tail),
    .route_now_i(route_now), .dst_now_i(swap_dst),
    .first_o(first), .route_cur_o(route_cur), .dst_cur_o(dst_cur)
  );

  lbt_launcher #(.DW(DW), .PW(PW), .CW(CW)) u_launch (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_idle_i(first),
    .seed_dst_i(seed_dst), .seed_word_i(seed_word), .iter_limit_i(iter_limit),
    .seed_gnt_i(out_gnt), .in_acc_i(in_acc), .in_first_i(first),
    .in_tail_i(in_tail), .sinking_i(route_cur == RT_SINK),
    .in_data_i(in_data), .in_src_i(in_src), .expire_i(expire),
    .start_acc_o(start_acc), .seed_pend_o(seed_pend),
    .seed_dst_o(seed_dst_q), .seed_word_o(seed_word_q),
    .running_o(running), .final_now_o(final_now), .rounds_o(rounds),
    .done_o(done), .held_word_o(held_word), .held_src_o(held_src)
  );

  lbt_watchdog #(.TW(TW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .run_i(running),
    .acc_i(in_acc), .limit_i(wd_limit), .expire_o(expire), .timeout_o(timeout)
  );

  always_comb begin
    out_req  = 1'b0;
    out_data = first ? swap_word : in_data;
    out_tail = in_tail;
    out_dst  = dst_cur;
    in_gnt   = 1'b0;
    loc_req  = 1'b0;
    if (seed_pend) begin
      out_req  = 1'b1;
      out_data = seed_word_q;
      out_tail = 1'b1;
      out_dst  = seed_dst_q;
    end else begin
      case (route_cur)
        RT_LOOP: begin
          out_req = in_req;
          in_gnt  = out_gnt;
        end
        RT_LOCAL: begin
          loc_req = in_req;
          in_gnt  = loc_gnt;
        end
        RT_SINK: in_gnt = 1'b1;
        default: in_gnt = 1'b0;
      endcase
    end
  end

  assign loc_data = in_data;
  assign loc_tail = in_tail;
  assign loc_src  = in_src;
  assign busy     = running;

  // R3
  burst_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_gnt && !out_tail && !seed_pend)
      |=> (!out_req || out_dst == $past(out_dst)));

  // R5
  seed_blocks_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_pend) |-> (rounds == '0 && !done && !timeout));
endmodule

// File: tb/burst_loop_tester_tb.sv
module burst_loop_tester_tb;
  localparam int DW = 36, PW = 4, CW = 8, TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loop_en = 0, start = 0, in_req = 0, in_tail = 0, out_gnt = 0, loc_gnt = 0;
  logic [PW-1:0] seed_dst = '0, in_src = '0;
  logic [DW-1:0] seed_word = '0, in_data = '0;
  logic [CW-1:0] iter_limit = '0;
  logic [TW-1:0] wd_limit = '0;
  logic in_gnt, out_req, out_tail, loc_req, loc_tail, busy, done, timeout;
  logic [DW-1:0] out_data, loc_data, held_word;
  logic [PW-1:0] out_dst, loc_src, held_src;
  logic [CW-1:0] rounds;
  int errors = 0, checks = 0;
  logic finished = 0;

  always #5 clk = ~clk;

  burst_loop_tester #(.DW(DW), .PW(PW), .FLD_LSB(0), .CW(CW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .start(start),
    .seed_dst(seed_dst), .seed_word(seed_word), .iter_limit(iter_limit),
    .wd_limit(wd_limit), .in_req(in_req), .in_gnt(in_gnt), .in_data(in_data),
    .in_tail(in_tail), .in_src(in_src), .out_req(out_req), .out_gnt(out_gnt),
    .out_data(out_data), .out_tail(out_tail), .out_dst(out_dst),
    .loc_req(loc_req), .loc_gnt(loc_gnt), .loc_data(loc_data),
    .loc_tail(loc_tail), .loc_src(loc_src), .busy(busy), .done(done),
    .timeout(timeout), .rounds(rounds), .held_word(held_word), .held_src(held_src)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] swp(input logic [DW-1:0] w, input logic [PW-1:0] s);
    return {w[DW-1:4], s};
  endfunction

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R5 reset busy", 64'(busy), 0);
    chk("R5 reset done", 64'(done), 0);
    chk("R8 reset timeout", 64'(timeout), 0);
    chk("R6 reset rounds", 64'(rounds), 0);
    chk("R4 reset out_req", 64'(out_req), 0);
  endtask

  task automatic t_local();
    loop_en = 0; in_req = 1; in_data = 36'h9_8765_4321; in_src = 4'h3; in_tail = 1;
    loc_gnt = 0; #1;
    chk("R1 loc_req", 64'(loc_req), 1);
    chk("R1 loc_data", 64'(loc_data), 64'h9_8765_4321);
    chk("R1 loc_src", 64'(loc_src), 3);
    chk("R1 out_req low", 64'(out_req), 0);
    chk("R4 in_gnt follows loc_gnt low", 64'(in_gnt), 0);
    loc_gnt = 1; #1;
    chk("R4 in_gnt follows loc_gnt high", 64'(in_gnt), 1);
    @(posedge clk); settle();
    in_req = 0; loc_gnt = 0;
  endtask

  task automatic t_loop();
    loop_en = 1; out_gnt = 0;
    in_req = 1; in_data = 36'h1_2345_6789; in_src = 4'h6; in_tail = 0; #1;
    chk("R2 out_dst from field", 64'(out_dst), 9);
    chk("R2 swapped word", 64'(out_data), 64'h1_2345_6786);
    chk("R4 in_gnt low while out_gnt low", 64'(in_gnt), 0);
    settle();
    chk("R4 stalled first word still swapped", 64'(out_data), 64'h1_2345_6786);
    out_gnt = 1; #1;
    chk("R4 in_gnt mirrors out_gnt", 64'(in_gnt), 1);
    settle();
    in_data = 36'hA_BCDE_0F0F; in_src = 4'h2; #1;
    chk("R3 middle word unchanged", 64'(out_data), 64'hA_BCDE_0F0F);
    chk("R3 middle word keeps dst", 64'(out_dst), 9);
    chk("R3 middle tail", 64'(out_tail), 0);
    settle();
    in_data = 36'h5_5555_5555; in_tail = 1; #1;
    chk("R3 last word unchanged", 64'(out_data), 64'h5_5555_5555);
    chk("R3 last tail", 64'(out_tail), 1);
    chk("R3 last keeps dst", 64'(out_dst), 9);
    settle();
    in_req = 0; out_gnt = 0; loop_en = 0;
  endtask

  task automatic ret(input logic [DW-1:0] w, input logic [PW-1:0] s);
    in_req = 1; in_data = w; in_src = s; in_tail = 1;
  endtask

  task automatic t_run();
    logic [DW-1:0] w;
    loop_en = 0; iter_limit = 3; wd_limit = 100;
    seed_dst = 4'h2; seed_word = 36'h0_0000_1115; start = 1;
    settle(); start = 0; out_gnt = 0; #1;
    chk("R5 busy", 64'(busy), 1);
    chk("R5 seed req", 64'(out_req), 1);
    chk("R5 seed dst", 64'(out_dst), 2);
    chk("R5 seed word", 64'(out_data), 64'h0_0000_1115);
    chk("R5 seed tail", 64'(out_tail), 1);
    in_req = 1; #1;
    chk("R5 ingress held during seed", 64'(in_gnt), 0);
    in_req = 0; out_gnt = 1;
    settle();
    w = 36'h0_0000_1115; ret(w, 4'hA); #1;
    chk("R6 loop with loop_en low dst", 64'(out_dst), 5);
    chk("R6 loop with loop_en low data", 64'(out_data), 64'(swp(w, 4'hA)));
    settle(); in_req = 0; #1;
    chk("R6 rounds after return 1", 64'(rounds), 1);
    start = 1; seed_dst = 4'hF;
    settle(); start = 0; #1;
    chk("R10 start ignored no seed", 64'(out_req), 0);
    chk("R10 rounds unchanged", 64'(rounds), 1);
    w = swp(w, 4'hA); ret(w, 4'hC); #1;
    chk("R2 second hop dst", 64'(out_dst), 10);
    settle(); in_req = 0;
    w = swp(w, 4'hC); ret(w, 4'h7); #1;
    chk("R7 final burst granted", 64'(in_gnt), 1);
    chk("R7 final burst not re-sent", 64'(out_req), 0);
    settle(); in_req = 0; #1;
    chk("R7 done", 64'(done), 1);
    chk("R7 busy low", 64'(busy), 0);
    chk("R7 rounds", 64'(rounds), 3);
    chk("R7 held word", 64'(held_word), 64'(w));
    chk("R7 held src", 64'(held_src), 7);
    out_gnt = 0;
  endtask

  task automatic t_limit0();
    iter_limit = 0; wd_limit = 0; seed_dst = 4'h1; seed_word = 36'h0_0000_00C4;
    start = 1; settle(); start = 0; out_gnt = 1; #1;
    chk("R5 restart clears done", 64'(done), 0);
    settle(); out_gnt = 0;
    ret(36'h0_0000_00C4, 4'hB); #1;
    chk("R7 limit0 absorbs first return", 64'(in_gnt), 1);
    settle(); in_req = 0; #1;
    chk("R7 limit0 done", 64'(done), 1);
    chk("R7 limit0 held src", 64'(held_src), 11);
  endtask

  task automatic t_timeout();
    iter_limit = 2; wd_limit = 5; start = 1;
    settle(); start = 0; out_gnt = 0;
    repeat (4) settle();
    chk("R8 no timeout after 4 idle edges", 64'(timeout), 0);
    settle();
    chk("R8 timeout after 5 idle edges", 64'(timeout), 1);
    chk("R8 run ended", 64'(busy), 0);
    chk("R8 seed withdrawn", 64'(out_req), 0);
    repeat (3) settle();
    chk("R8 timeout sticky", 64'(timeout), 1);
  endtask

  task automatic t_race();
    iter_limit = 1; wd_limit = 5; start = 1;
    settle(); start = 0; out_gnt = 1; #1;
    chk("R5 restart clears timeout", 64'(timeout), 0);
    settle(); out_gnt = 0;
    repeat (3) settle();
    ret(36'h0_0000_0042, 4'h4); #1;
    chk("R9 final return offered on expiry edge", 64'(in_gnt), 1);
    settle(); in_req = 0; #1;
    chk("R9 accept wins no timeout", 64'(timeout), 0);
    chk("R9 done on expiry edge", 64'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_local();
    t_loop();
    t_run();
    t_limit0();
    t_timeout();
    t_race();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule